// File: doc/BRIEF.md
# Forty-Bit Free-Running Time Base

This block holds a wide up-counter that software uses as a monotonic time reference. The counter advances by one on every clock in which an externally generated tick strobe is high and the run flag is set. It is never reloaded and raises no interrupt. After all ones it rolls over to zero. The tick strobe comes from elsewhere; a rate near 983 kHz is typical.

Software reaches the counter through a small register port with two word addresses. The low word at offset 0x60 gives count bits 31:0. The high word at offset 0x64 gives count bits 39:32 in its bottom byte and the run flag at bit 8. A write to the high word sets or clears the run flag.

Software reads the low word first and the high word second. Each low read copies the upper count bits into a shadow register, and the next high read returns that copy. A carry out of the low word between the two reads therefore cannot tear the joined value. The counter width, the data width and the run-flag position are parameters.

Top module: `timebase40`

## Requirements
- R1: After reset the count is 0, the run flag is 0 and `rdata` is 0.
- R2: The count rises by exactly one at each clock edge where the run flag is 1 and `tick_en` is 1. At any other edge it does not change.
- R3: From all ones (2^CNT_W − 1) the next counted tick gives 0.
- R4: Clearing the run flag freezes the count at its value. Setting it again resumes counting from that value, and nothing else changes the count.
- R5: A write to 0x64 loads the run flag from `wdata[EN_POS]` (bit 8 by default) and takes effect from the following edge. The other write bits, writes to 0x60 and writes to any other address have no effect.
- R6: A read at 0x60 returns, one cycle later on `rdata`, count bits DATA_W−1:0 as they were at the read edge.
- R7: A read at 0x60 captures the upper count bits of that same edge. The next read at 0x64 returns the captured bits, even if the count has carried into the upper bits since.
- R8: A read at 0x64 with no low read since the previous high read returns the live upper count bits.
- R9: A high-word read returns the upper count bits in bits CNT_W−DATA_W−1:0 and the run flag at bit EN_POS. All bits above EN_POS read as 0.
- R10: A read at any address other than 0x60 or 0x64 returns 0.
- R11: `rdata` keeps its value in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count strobe, one clock wide per tick |
| rd_en | input | 1 | Read request at `addr` |
| wr_en | input | 1 | Write request at `addr` |
| addr | input | 8 | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the cycle after `rd_en` |

## Verification
Two instances are exercised side by side: the full 40/32 split and a reduced 12/8 split. The reduced instance can reach rollover and a low-to-high carry within a short run.

Directed steps separate four cases:
- holding when the run flag is clear versus counting when it is set;
- decoded versus ignored writes;
- a shadowed high read, which returns the old upper bits, versus a live one, which returns the carried value;
- rollover.

Random mixes of reads, writes, addresses and tick patterns are then checked against a bench model. They catch ordering errors between a run-flag change and a tick at the same edge, and between a read and a count change at the same edge.

// File: rtl/tbc_pkg.sv
// Shared constants and address decode for the time-base counter.
// Assumes byte offsets on an 8-bit address; only two offsets decode.
package tbc_pkg;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] OFS_LOW  = 8'h60;
    localparam logic [ADDR_W-1:0] OFS_HIGH = 8'h64;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_LOW,
        SEL_HIGH
    } sel_e;

    // Map a byte offset to the register it selects.
    function automatic sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        if (a == OFS_LOW) begin
            return SEL_LOW;
        end else if (a == OFS_HIGH) begin
            return SEL_HIGH;
        end
        return SEL_NONE;
    endfunction
endpackage

// File: rtl/tbc_counter.sv
// Free-running up-counter. It advances when both run and tick_en are high.
// Assumes tick_en is a single-cycle strobe in the clk domain. Wraps modulo 2^CNT_W.
module tbc_counter #(
    parameter int CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick_en,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] TOPV = {CNT_W{1'b1}};

    // Count register: clear on reset, step on a qualified tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (run && tick_en) begin
            count <= count + ONE;
        end
    end

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_en) |=> (count == $past(count) + ONE));

    p_hold_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && tick_en) |=> $stable(count));

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_en && count == TOPV) |=> (count == '0));
endmodule

// File: rtl/tbc_regif.sv
// Register port for the time base: run flag, upper-bit shadow and read mux.
// Assumes CNT_W > DATA_W, with EN_POS between the upper-bit field and DATA_W-1.
// Read data is registered and appears one cycle after rd_en.
module tbc_regif
    import tbc_pkg::*;
#(
    parameter int CNT_W  = 40,
    parameter int DATA_W = 32,
    parameter int EN_POS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    output logic              run,
    output logic [DATA_W-1:0] rdata
);
    localparam int HI_W = CNT_W - DATA_W;

    sel_e              sel;
    logic [HI_W-1:0]   shadow;
    logic              pend;
    logic [HI_W-1:0]   hi_src;
    logic [DATA_W-1:0] hi_word;

    // Decode the offset once for all processes.
    assign sel = decode_ofs(addr);

    // Run flag: only a high-word write changes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
        end else if (wr_en && sel == SEL_HIGH) begin
            run <= wdata[EN_POS];
        end
    end

    // Shadow: a low read captures the upper bits; a high read consumes them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
            pend   <= 1'b0;
        end else if (rd_en && sel == SEL_LOW) begin
            shadow <= count[CNT_W-1:DATA_W];
            pend   <= 1'b1;
        end else if (rd_en && sel == SEL_HIGH) begin
            pend   <= 1'b0;
        end
    end

    // High-word image: shadowed or live upper bits, plus the run flag.
    always_comb begin
        hi_src              = pend ? shadow : count[CNT_W-1:DATA_W];
        hi_word             = '0;
        hi_word[HI_W-1:0]   = hi_src;
        hi_word[EN_POS]     = run;
    end

    // Read data register: updates only on a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (sel)
                SEL_LOW:  rdata <= count[DATA_W-1:0];
                SEL_HIGH: rdata <= hi_word;
                default:  rdata <= '0;
            endcase
        end
    end

    p_low_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_LOW) |=> (rdata == $past(count[DATA_W-1:0])));

    p_snap_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_LOW) |=> (pend && shadow == $past(count[CNT_W-1:DATA_W])));

    p_hi_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_HIGH) |=> ((rdata >> (EN_POS + 1)) == '0));

    p_hi_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_HIGH) |=> (rdata[EN_POS] == $past(run)));

    p_other_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_NONE) |=> (rdata == '0));

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    p_flag_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel == SEL_HIGH) |=> $stable(run));
endmodule

// File: rtl/timebase40.sv
// Top of the time base: a free-running counter and its register port.
// Assumes tick_en is produced elsewhere and is synchronous to clk.
module timebase40 #(
    parameter int CNT_W  = 40,
    parameter int DATA_W = 32,
    parameter int EN_POS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_en,
    input  logic                       rd_en,
    input  logic                       wr_en,
    input  logic [tbc_pkg::ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata
);
    logic             run;
    logic [CNT_W-1:0] count;

    tbc_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick_en (tick_en),
        .count   (count)
    );

    tbc_regif #(.CNT_W(CNT_W), .DATA_W(DATA_W), .EN_POS(EN_POS)) u_regif (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (rd_en),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .count (count),
        .run   (run),
        .rdata (rdata)
    );
endmodule

// File: tb/test_timebase40.sv
// Bench: two instances (full 40/32 and reduced 12/8) share one stimulus bus.
// A bench model built from the requirements predicts rdata for both instances.
module test_timebase40;
    logic        clk = 1'b0;
    logic        rst_n, tick_en, rd_en, wr_en;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata_big;
    logic [7:0]  rdata_sml;

    always #4 clk = ~clk;

    timebase40 i_timebase40 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rd_en(rd_en),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata_big)
    );

    timebase40 #(.CNT_W(12), .DATA_W(8), .EN_POS(4)) i_timebase40_small (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rd_en(rd_en),
        .wr_en(wr_en), .addr(addr), .wdata(wdata[7:0]), .rdata(rdata_sml)
    );

    int checks = 0;
    int errors = 0;

    longint unsigned m_cnt[2], m_sh[2], m_rd[2];
    bit              m_en[2], m_shv[2];
    int unsigned     CW[2] = '{40, 12};
    int unsigned     DW[2] = '{32, 8};
    int unsigned     EB[2] = '{8, 4};

    function automatic longint unsigned mask(input int unsigned w);
        return (64'd1 << w) - 64'd1;
    endfunction

    // Advance the model by one edge, using the inputs driven for that edge.
    task automatic model_edge();
        for (int k = 0; k < 2; k++) begin
            bit              old_en = m_en[k];
            longint unsigned hi     = m_cnt[k] >> DW[k];
            if (rd_en) begin
                if (addr == 8'h60) begin
                    m_rd[k]  = m_cnt[k] & mask(DW[k]);
                    m_sh[k]  = hi;
                    m_shv[k] = 1'b1;
                end else if (addr == 8'h64) begin
                    m_rd[k]  = (m_shv[k] ? m_sh[k] : hi) |
                               (longint'(old_en) << EB[k]);
                    m_shv[k] = 1'b0;
                end else begin
                    m_rd[k] = 0;
                end
            end
            if (wr_en && addr == 8'h64) m_en[k] = wdata[EB[k]];
            if (old_en && tick_en) m_cnt[k] = (m_cnt[k] + 1) & mask(CW[k]);
        end
    endtask

    task automatic check(input string req, input longint unsigned act,
                         input longint unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, model at posedge, compare at next negedge.
    task automatic step(input bit rd, input bit wr, input logic [7:0] a,
                        input logic [31:0] d, input bit tk, input string req);
        rd_en = rd; wr_en = wr; addr = a; wdata = d; tick_en = tk;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; tick_en = 1'b0;
        check(req, rdata_big, m_rd[0]);
        check(req, rdata_sml, m_rd[1]);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        longint unsigned hi_old;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; tick_en = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
        addr = 8'h0; wdata = 32'h0;
        for (int k = 0; k < 2; k++) begin
            m_cnt[k] = 0; m_sh[k] = 0; m_rd[k] = 0; m_en[k] = 0; m_shv[k] = 0;
        end
        repeat (3) @(negedge clk);
        check("R1", rdata_big, 0);
        check("R1", rdata_sml, 0);
        rst_n = 1'b1;
        // R1: counter and run flag are clear after reset
        step(1, 0, 8'h60, 0, 1, "R1");
        check("R1", rdata_big, 0);
        step(1, 0, 8'h64, 0, 1, "R1");
        check("R1", rdata_big, 0);

        // R5: set the run flag in both instances (bits 8 and 4)
        step(0, 1, 8'h64, 32'h110, 0, "R5");
        repeat (3) step(0, 0, 8'h00, 0, 0, "R2");
        repeat (10) step(0, 0, 8'h00, 0, 1, "R2");
        step(1, 0, 8'h60, 0, 0, "R2");
        check("R2", rdata_big, 10);
        check("R2", rdata_sml, 10);

        // R5: writes to the low word or to unknown offsets are ignored
        step(0, 1, 8'h60, 32'hFFFF_FFFF, 0, "R5");
        step(0, 1, 8'h68, 32'h0, 0, "R5");
        step(0, 1, 8'h00, 32'h0, 1, "R5");
        step(1, 0, 8'h60, 0, 0, "R5");
        check("R5", rdata_big, 11);

        // R4: clear the run flag while every other bit is set; count freezes
        step(0, 1, 8'h64, 32'hFFFF_FEEF, 0, "R4");
        repeat (5) step(0, 0, 8'h00, 0, 1, "R4");
        step(1, 0, 8'h60, 0, 0, "R4");
        check("R4", rdata_big, 11);
        step(1, 0, 8'h64, 0, 0, "R9");
        check("R9", rdata_big, 0);
        step(0, 1, 8'h64, 32'h110, 0, "R4");
        repeat (3) step(0, 0, 8'h00, 0, 1, "R4");
        step(1, 0, 8'h60, 0, 0, "R4");
        check("R4", rdata_big, 14);
        // R9: run flag visible at bit 8, upper bits zero
        step(1, 0, 8'h64, 0, 0, "R9");
        check("R9", rdata_big, 32'h100);
        // R10: unknown offsets read zero
        step(1, 0, 8'h68, 0, 0, "R10");
        check("R10", rdata_big, 0);
        // R11: no read, rdata holds
        step(0, 0, 8'h60, 0, 1, "R11");

        // R3: bring the reduced instance to all ones, then one tick
        while (m_cnt[1] != 64'hFFF) step(0, 0, 8'h00, 0, 1, "R11");
        step(1, 0, 8'h60, 0, 0, "R3");
        check("R3", rdata_sml, 8'hFF);
        step(0, 0, 8'h00, 0, 1, "R3");
        step(1, 0, 8'h60, 0, 0, "R3");
        check("R3", rdata_sml, 0);
        step(1, 0, 8'h64, 0, 0, "R3");
        check("R3", rdata_sml, 8'h10);

        // R7/R8: low read at 0xFF while the same edge carries into upper bits
        while ((m_cnt[1] & 64'hFF) != 64'hFF) step(0, 0, 8'h00, 0, 1, "R11");
        hi_old = m_cnt[1] >> 8;
        step(1, 0, 8'h60, 0, 1, "R7");
        check("R7", rdata_sml, 8'hFF);
        step(1, 0, 8'h64, 0, 0, "R7");
        check("R7", rdata_sml, hi_old | 8'h10);
        step(1, 0, 8'h64, 0, 0, "R8");
        check("R8", rdata_sml, ((hi_old + 1) & 64'hF) | 8'h10);

        // Random mix checked against the model
        for (int n = 0; n < 3000; n++) begin
            bit          rd = ($urandom % 2) == 0;
            bit          wr = ($urandom % 8) == 0;
            bit          tk = ($urandom % 4) != 0;
            logic [31:0] d  = $urandom;
            logic [7:0]  a;
            string       tag;
            case ($urandom % 5)
                0, 1:    a = 8'h60;
                2:       a = 8'h64;
                3:       a = 8'h68;
                default: a = 8'($urandom);
            endcase
            if (($urandom % 4) != 0) d = d | 32'h110;
            if (!rd)              tag = "R11";
            else if (a == 8'h60)  tag = "R6";
            else if (a == 8'h64)  tag = "R9";
            else                  tag = "R10";
            step(rd, wr, a, d, tk, tag);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule